// File: doc/BRIEF.md
# External Bus Turnaround Idle Inserter

This block sequences CPU read and write requests onto a shared external data bus. Each accepted request becomes one external cycle. A read takes three states and a write takes two. Between two consecutive accesses that change direction, the block can add one idle state. During that state nothing is selected and nothing drives the data bus, so a slow device that is still releasing the bus cannot collide with the next driver.

The block has two separate turnaround enables, one for a read followed by a write and one for a write followed by a read. Both are held in a small configuration register that loads from the cfg_* pins on a strobe. Requests use a valid/ready handshake. Each state lasts one clock. The requester can chain accesses with no gap by presenting the next request while the current cycle is in its final state.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset, all chip selects and both strobes are high (inactive), bus_dout_en and rd_data are 0, req_ready is 1, the read-to-write idle enable is 1 and the write-to-read idle enable is 0.
- R2: A read cycle takes three states T1, T2, T3. The selected chip select is low in all three states and bus_rd_n is low in T2 and T3. bus_din is captured into rd_data at the end of T3, so it is visible from the next clock onward.
- R3: A write cycle takes two states T1, T2. bus_dout_en is high and bus_dout carries the write data in T1 and T2. bus_wr_n is low in T2 only, and bus_rd_n stays high.
- R4: When a write is accepted after a read and the read-to-write enable is 1, exactly one idle state comes before the write's T1.
- R5: When a read is accepted after a write and the write-to-read enable is 1, exactly one idle state comes before the read's T1.
- R6: When the enable for a direction change is 0, the new cycle's T1 follows at once, with no idle state.
- R7: Two accesses in the same direction never have an idle state between them, whatever the enables hold.
- R8: The first access after reset never gets an idle state. The previous direction counts as the direction of the last completed access, however long ago that access ended.
- R9: During an idle state, all chip selects, bus_rd_n and bus_wr_n are high and bus_dout_en is 0.
- R10: req_ready is 1 while no cycle is running and during the final state of a cycle (read T3, write T2), and 0 otherwise. A request is accepted on a clock edge where req_valid and req_ready are both 1.
- R11: Only the chip select bus_cs_n[req_area] is driven low, and bus_addr holds the accepted address through every state of the cycle, including its idle state.
- R12: A clock edge with cfg_we = 1 loads cfg_idle_r2w and cfg_idle_w2r into the two enables. A request accepted on that same edge still uses the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_area | input | AREA_W | Area index selecting the chip select |
| req_wdata | input | DATA_W | Write data |
| cfg_we | input | 1 | Load the turnaround enables |
| cfg_idle_r2w | input | 1 | New read-to-write idle enable |
| cfg_idle_w2r | input | 1 | New write-to-read idle enable |
| bus_addr | output | ADDR_W | External address bus |
| bus_cs_n | output | AREAS | Active-low chip select per area |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_dout | output | DATA_W | Data driven onto the bus |
| bus_dout_en | output | 1 | Data bus output enable |
| bus_din | input | DATA_W | Data read from the bus |
| rd_data | output | DATA_W | Captured read data |

## Verification
A request accepted at a clock edge shows its first state, either the idle state or T1, in the very next cycle. Each following state then lasts exactly one cycle. Read data appears on rd_data one cycle after the T3 state. req_ready depends only on the current state, so it can be compared in the same cycle as the pins. The bench appends the expected per-cycle pin picture of every request it sees accepted to a queue, and at each falling edge it compares the pins with the head of that queue. An empty queue stands for the quiet bus.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_TURN,
        PH_T1,
        PH_T2,
        PH_T3
    } phase_e;

    typedef enum logic [1:0] {
        DIR_NONE,
        DIR_READ,
        DIR_WRITE
    } dir_e;

    typedef struct packed {
        logic idle_r2w;
        logic idle_w2r;
    } turn_cfg_t;

    typedef struct packed {
        logic cs_act;
        logic rd_act;
        logic wr_act;
        logic drive;
    } strobe_t;

    function automatic logic is_final(input phase_e ph, input logic wr);
        return (wr && ph == PH_T2) || (!wr && ph == PH_T3);
    endfunction

    function automatic dir_e dir_of(input logic wr);
        return wr ? DIR_WRITE : DIR_READ;
    endfunction

    function automatic strobe_t strobe_decode(input phase_e ph, input logic wr);
        strobe_t s;
        s = '0;
        case (ph)
            PH_T1: begin
                s.cs_act = 1'b1;
                s.drive  = wr;
            end
            PH_T2: begin
                s.cs_act = 1'b1;
                s.rd_act = !wr;
                s.wr_act = wr;
                s.drive  = wr;
            end
            PH_T3: begin
                s.cs_act = 1'b1;
                s.rd_act = 1'b1;
            end
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/xbus_cfg_reg.sv
module xbus_cfg_reg
    import xbus_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cfg_we,
    input  logic      cfg_idle_r2w,
    input  logic      cfg_idle_w2r,
    output turn_cfg_t cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.idle_r2w <= 1'b1;
            cfg.idle_w2r <= 1'b0;
        end else if (cfg_we) begin
            cfg.idle_r2w <= cfg_idle_r2w;
            cfg.idle_w2r <= cfg_idle_w2r;
        end
    end

    assert_cfg_load_R12: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (cfg.idle_r2w == $past(cfg_idle_r2w) && cfg.idle_w2r == $past(cfg_idle_w2r)));

    assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg));

endmodule

// File: rtl/xbus_dir_track.sv
module xbus_dir_track
    import xbus_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      complete,
    input  logic      cur_write,
    input  logic      new_write,
    input  turn_cfg_t cfg,
    output logic      need_turn,
    output dir_e      prev_dir
);

    dir_e eff_prev;

    // the cycle finishing on this edge counts as the previous one
    assign eff_prev = complete ? dir_of(cur_write) : prev_dir;

    always_comb begin
        need_turn = 1'b0;
        if (eff_prev == DIR_READ && new_write)
            need_turn = cfg.idle_r2w;
        else if (eff_prev == DIR_WRITE && !new_write)
            need_turn = cfg.idle_w2r;
    end

    always_ff @(posedge clk) begin
        if (rst)
            prev_dir <= DIR_NONE;
        else if (complete)
            prev_dir <= dir_of(cur_write);
    end

    // R8: once a cycle completes, a direction is always known
    assert_prev_known_R8: assert property (@(posedge clk) disable iff (rst)
        complete |=> prev_dir != DIR_NONE);

endmodule

// File: rtl/xbus_phase_fsm.sv
module xbus_phase_fsm
    import xbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  logic   req_write,
    input  logic   need_turn,
    output logic   req_ready,
    output logic   accept,
    output logic   complete,
    output logic   cur_write,
    output phase_e phase
);

    phase_e phase_nx;
    phase_e start_ph;

    assign complete  = (phase != PH_IDLE) && is_final(phase, cur_write);
    assign req_ready = (phase == PH_IDLE) || complete;
    assign accept    = req_valid && req_ready;
    assign start_ph  = need_turn ? PH_TURN : PH_T1;

    always_comb begin
        phase_nx = phase;
        case (phase)
            PH_IDLE: if (accept) phase_nx = start_ph;
            PH_TURN: phase_nx = PH_T1;
            PH_T1:   phase_nx = PH_T2;
            PH_T2:   if (!cur_write) phase_nx = PH_T3;
                     else phase_nx = accept ? start_ph : PH_IDLE;
            PH_T3:   phase_nx = accept ? start_ph : PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cur_write <= 1'b0;
        end else begin
            phase <= phase_nx;
            if (accept) cur_write <= req_write;
        end
    end

    assert_turn_then_t1_R9: assert property (@(posedge clk) disable iff (rst)
        phase == PH_TURN |=> phase == PH_T1);

    assert_read_len_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_T2 && !cur_write) |=> phase == PH_T3);

    assert_write_len_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_T2 && cur_write) |=> (phase != PH_T3));

    assert_accept_start_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (phase == PH_TURN || phase == PH_T1));

endmodule

// File: rtl/xbus_pin_drive.sv
module xbus_pin_drive
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int AREAS  = 8,
    parameter int AREA_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [AREA_W-1:0] ld_area,
    input  logic [DATA_W-1:0] ld_wdata,
    input  phase_e            phase,
    input  logic              cur_write,
    input  logic [DATA_W-1:0] bus_din,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [AREAS-1:0]  bus_cs_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_en,
    output logic [DATA_W-1:0] rd_data
);

    logic [ADDR_W-1:0] addr_q;
    logic [AREA_W-1:0] area_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    strobe_t           stb;

    assign stb = strobe_decode(phase, cur_write);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            area_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (load) begin
                addr_q  <= ld_addr;
                area_q  <= ld_area;
                wdata_q <= ld_wdata;
            end
            if (phase == PH_T3) rdata_q <= bus_din;
        end
    end

    for (genvar g = 0; g < AREAS; g++) begin : g_cs
        assign bus_cs_n[g] = !(stb.cs_act && area_q == AREA_W'(g));
    end

    assign bus_addr    = addr_q;
    assign bus_rd_n    = !stb.rd_act;
    assign bus_wr_n    = !stb.wr_act;
    assign bus_dout    = wdata_q;
    assign bus_dout_en = stb.drive;
    assign rd_data     = rdata_q;

    assert_quiet_turn_R9: assert property (@(posedge clk) disable iff (rst)
        phase == PH_TURN |-> (&bus_cs_n && bus_rd_n && bus_wr_n && !bus_dout_en));

    assert_addr_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_T2 || phase == PH_T3) |-> $stable(bus_addr));

    assert_one_cs_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~bus_cs_n));

    assert_no_fight_R3: assert property (@(posedge clk) disable iff (rst)
        !(bus_dout_en && !bus_rd_n));

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int AREAS  = 8,
    localparam int AREA_W = (AREAS > 1) ? $clog2(AREAS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [AREA_W-1:0] req_area,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_we,
    input  logic              cfg_idle_r2w,
    input  logic              cfg_idle_w2r,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [AREAS-1:0]  bus_cs_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_en,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] rd_data
);

    turn_cfg_t cfg;
    phase_e    phase;
    dir_e      prev_dir;
    logic      need_turn;
    logic      accept;
    logic      complete;
    logic      cur_write;

    xbus_cfg_reg u_cfg (
        .clk          (clk),
        .rst          (rst),
        .cfg_we       (cfg_we),
        .cfg_idle_r2w (cfg_idle_r2w),
        .cfg_idle_w2r (cfg_idle_w2r),
        .cfg          (cfg)
    );

    xbus_dir_track u_dir (
        .clk       (clk),
        .rst       (rst),
        .complete  (complete),
        .cur_write (cur_write),
        .new_write (req_write),
        .cfg       (cfg),
        .need_turn (need_turn),
        .prev_dir  (prev_dir)
    );

    xbus_phase_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .need_turn (need_turn),
        .req_ready (req_ready),
        .accept    (accept),
        .complete  (complete),
        .cur_write (cur_write),
        .phase     (phase)
    );

    xbus_pin_drive #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .AREAS  (AREAS),
        .AREA_W (AREA_W)
    ) u_pins (
        .clk         (clk),
        .rst         (rst),
        .load        (accept),
        .ld_addr     (req_addr),
        .ld_area     (req_area),
        .ld_wdata    (req_wdata),
        .phase       (phase),
        .cur_write   (cur_write),
        .bus_din     (bus_din),
        .bus_addr    (bus_addr),
        .bus_cs_n    (bus_cs_n),
        .bus_rd_n    (bus_rd_n),
        .bus_wr_n    (bus_wr_n),
        .bus_dout    (bus_dout),
        .bus_dout_en (bus_dout_en),
        .rd_data     (rd_data)
    );

    // R4 R5 R7 R8: an idle state only ever separates two opposite directions
    assert_turn_dir_R7: assert property (@(posedge clk) disable iff (rst)
        phase == PH_TURN |-> (prev_dir != DIR_NONE && (prev_dir == DIR_WRITE) != cur_write));

    assert_turn_enabled_R6: assert property (@(posedge clk) disable iff (rst)
        phase == PH_TURN |-> (cur_write ? $past(cfg.idle_r2w) : $past(cfg.idle_w2r)));

endmodule

// File: tb/sim_ext_bus_seq.sv
module sim_ext_bus_seq;

    localparam int AW = 24;
    localparam int DW = 16;
    localparam int NA = 8;
    localparam int NW = 3;

    typedef struct {
        bit          act;
        bit          rd;
        bit          wr;
        bit          oe;
        int          area;
        bit [AW-1:0] addr;
        bit [DW-1:0] wdata;
        bit          cap;
        int          tag;
    } pic_t;

    logic          clk = 0;
    logic          rst = 1;
    logic          req_valid = 0;
    logic          req_ready;
    logic          req_write = 0;
    logic [AW-1:0] req_addr = '0;
    logic [NW-1:0] req_area = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          cfg_we = 0;
    logic          cfg_idle_r2w = 0;
    logic          cfg_idle_w2r = 0;
    logic [AW-1:0] bus_addr;
    logic [NA-1:0] bus_cs_n;
    logic          bus_rd_n;
    logic          bus_wr_n;
    logic [DW-1:0] bus_dout;
    logic          bus_dout_en;
    logic [DW-1:0] bus_din;
    logic [DW-1:0] rd_data;

    int  errors = 0;
    int  checks = 0;
    bit  done = 0;
    pic_t q[$];
    bit  m_r2w = 1;
    bit  m_w2r = 0;
    bit  have_last = 0;
    bit  last_w = 0;
    bit [DW-1:0] exp_rdata = '0;

    always #2 clk = ~clk;

    function automatic bit [DW-1:0] devdata(input bit [AW-1:0] a);
        return a[DW-1:0] ^ 16'h5A3C;
    endfunction

    // external device: drives data only while the read strobe is low
    assign bus_din = !bus_rd_n ? devdata(bus_addr) : 16'h0000;

    ext_bus_seq u0 (.*);

    task automatic chk(input bit ok, input int tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_now();
        pic_t e;
        bit [NA-1:0] cs_exp;
        if (q.size() > 0) e = q[0];
        else begin
            e.act = 0; e.rd = 0; e.wr = 0; e.oe = 0; e.area = 0;
            e.addr = '0; e.wdata = '0; e.cap = 0; e.tag = 9;
        end
        cs_exp = '1;
        if (e.act) cs_exp[e.area] = 1'b0;
        chk(bus_cs_n == cs_exp, e.tag, "cs_n", bus_cs_n, cs_exp);
        chk(bus_rd_n == !e.rd, e.tag, "rd_n", bus_rd_n, !e.rd);
        chk(bus_wr_n == !e.wr, e.tag, "wr_n", bus_wr_n, !e.wr);
        chk(bus_dout_en == e.oe, e.tag, "dout_en", bus_dout_en, e.oe);
        if (e.act) chk(bus_addr == e.addr, 11, "addr", bus_addr, e.addr);
        if (e.oe) chk(bus_dout == e.wdata, 3, "dout", bus_dout, e.wdata);
        chk(req_ready == (q.size() <= 1), 10, "ready", req_ready, q.size() <= 1);
        chk(rd_data == exp_rdata, 2, "rd_data", rd_data, exp_rdata);
    endtask

    function automatic pic_t mk(input bit act, input bit rd, input bit wr, input bit oe,
                                input int area, input bit [AW-1:0] a, input bit [DW-1:0] d,
                                input bit cap, input int tag);
        pic_t p;
        p.act = act; p.rd = rd; p.wr = wr; p.oe = oe; p.area = area;
        p.addr = a; p.wdata = d; p.cap = cap; p.tag = tag;
        return p;
    endfunction

    // one clock: compare, drive, update the model; returns whether accepted
    task automatic step(input bit v, input bit w, input bit [AW-1:0] a, input int ar,
                        input bit [DW-1:0] d, input bit we, input bit r2w, input bit w2r,
                        output bit acc);
        bit turn;
        int t1tag;
        @(negedge clk);
        compare_now();
        acc = v && (q.size() <= 1);
        req_valid = v; req_write = w; req_addr = a; req_area = NW'(ar); req_wdata = d;
        cfg_we = we; cfg_idle_r2w = r2w; cfg_idle_w2r = w2r;
        if (q.size() > 0) begin
            if (q[0].cap) exp_rdata = devdata(q[0].addr);   // R2 capture at end of T3
            void'(q.pop_front());
        end
        if (acc) begin
            turn = have_last && (last_w != w) && (w ? m_r2w : m_w2r);
            if (!have_last) t1tag = 8;                       // R8 first access
            else if (last_w == w) t1tag = 7;                 // R7 same direction
            else if (turn) t1tag = 11;
            else t1tag = 6;                                  // R6 enable cleared
            if (turn) q.push_back(mk(0, 0, 0, 0, ar, a, d, 0, w ? 4 : 5)); // R4 / R5, quiet per R9
            if (w) begin
                q.push_back(mk(1, 0, 0, 1, ar, a, d, 0, t1tag));
                q.push_back(mk(1, 0, 1, 1, ar, a, d, 0, 3));
            end else begin
                q.push_back(mk(1, 0, 0, 0, ar, a, d, 0, t1tag));
                q.push_back(mk(1, 1, 0, 0, ar, a, d, 0, 2));
                q.push_back(mk(1, 1, 0, 0, ar, a, d, 1, 2));
            end
            have_last = 1; last_w = w;
        end
        if (we) begin m_r2w = r2w; m_w2r = w2r; end          // R12 after this edge
    endtask

    task automatic issue(input bit w, input bit [AW-1:0] a, input int ar, input bit [DW-1:0] d);
        bit acc;
        acc = 0;
        while (!acc) step(1, w, a, ar, d, 0, 0, 0, acc);
    endtask

    task automatic idle_clk(input int n);
        bit acc;
        for (int i = 0; i < n; i++) step(0, 0, '0, 0, '0, 0, 0, 0, acc);
    endtask

    task automatic drain();
        bit acc;
        while (q.size() > 0) step(0, 0, '0, 0, '0, 0, 0, 0, acc);
        step(0, 0, '0, 0, '0, 0, 0, 0, acc);
    endtask

    task automatic set_cfg(input bit r2w, input bit w2r);
        bit acc;
        step(0, 0, '0, 0, '0, 1, r2w, w2r, acc);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R10 watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        bit acc;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset picture
        chk(bus_cs_n == '1, 1, "reset cs_n", bus_cs_n, '1);
        chk(bus_rd_n && bus_wr_n, 1, "reset strobes", {bus_rd_n, bus_wr_n}, 2'b11);
        chk(!bus_dout_en, 1, "reset dout_en", bus_dout_en, 0);
        chk(rd_data == '0, 1, "reset rd_data", rd_data, 0);
        chk(req_ready, 1, "reset ready", req_ready, 1);
        // R8 first read, R7 read-read, R1/R4 default r2w gives idle
        issue(0, 24'h000100, 2, 16'h0);
        issue(0, 24'h000204, 2, 16'h0);
        issue(1, 24'h000308, 5, 16'hBEEF);
        issue(1, 24'h00030A, 5, 16'h1234);
        // R1/R6 default w2r is 0: no idle
        issue(0, 24'h000410, 0, 16'h0);
        drain();
        // R12 enable write-to-read idle; R5
        set_cfg(1, 1);
        issue(1, 24'h000500, 7, 16'hA5A5);
        issue(0, 24'h000502, 7, 16'h0);
        // R8 gap: direction remembered across idle time
        drain();
        idle_clk(3);
        issue(1, 24'h000600, 1, 16'h0F0F);
        drain();
        // R6 both off
        set_cfg(0, 0);
        issue(0, 24'h000700, 3, 16'h0);
        issue(1, 24'h000702, 3, 16'h7777);
        issue(0, 24'h000704, 4, 16'h0);
        drain();
        // R12 config write on the same edge as an accept uses the old value
        step(1, 1, 24'h000800, 6, 16'h3C3C, 1, 1, 1, acc);
        if (!acc) issue(1, 24'h000800, 6, 16'h3C3C);
        issue(0, 24'h000802, 6, 16'h0);
        drain();
        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            int r;
            r = int'($urandom_range(0, 9));
            if (r == 0 && q.size() == 0)
                set_cfg(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            else if (r < 3)
                idle_clk(1);
            else
                issue(1'($urandom_range(0, 1)), AW'($urandom), int'($urandom_range(0, NA - 1)),
                      DW'($urandom));
        end
        drain();
        finish_run();
    end

endmodule